// File: doc/BRIEF.md
# Timer Channel Event Flag with Guarded Clear

This block is a single timer channel. It is controlled through one 8-bit status and control word on a CPU register bus. The channel runs in one of two modes:

- **Capture mode:** it watches a pin for a selected edge and copies the shared free-running counter into its 16-bit channel register.
- **Compare mode:** it flags the cycles in which the counter equals the channel register.

Either kind of event raises a sticky event flag. The interrupt line is the flag gated by an enable bit.

The flag is guarded. Software cannot clear it with a plain write. The CPU must first read the word while the flag is 1, which arms the clear. It then writes a 0 into the flag bit. Any event that lands after the arming read cancels the arm, so the write of 0 does nothing. The later event is therefore never lost.

A build-time option removes the upper mode-select bit for channels that support only the simpler mode set.

Top module: `tmr_chan_flag`

## Requirements
- R1: After synchronous active-low reset, the whole status word reads 0x00 and `irq` is 0.
- R2: Status word layout is bit 7 flag, bit 6 interrupt enable, bit 5 mode-select high, bit 4 mode-select low, bits 3:2 edge select (high, low), bit 1 overflow-toggle, bit 0 max-duty. Bits 6:0 read back as written.
- R3: In capture mode (both mode-select bits 0), an active pin edge sets the flag one clock after the edge is seen. Edge select 01 means rising, 10 means falling, and 11 means both.
- R4: In capture mode with edge select 00, pin edges set no flag and leave the channel register unchanged.
- R5: On a capture, the counter value present in the edge cycle is loaded into the channel register in the same clock in which the flag sets.
- R6: In compare mode (either mode-select bit 1), the flag sets one clock after a cycle in which the counter equals the channel register.
- R7: A read of the status word that sees the flag at 1, followed by a write with bit 7 at 0, clears the flag.
- R8: A write of 0 to bit 7 that was not preceded by a flag-set read leaves the flag set.
- R9: If an event occurs after the arming read and before the write of 0, that write leaves the flag set.
- R10: Writing 1 to bit 7 never sets the flag.
- R11: `irq` is 1 exactly when the flag and the interrupt enable bit are both 1.
- R12: With `HAS_MSB` = 0, bit 5 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address decode hit for the status word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status word read data |
| cnt_val | input | CNT_W | Shared free-running counter value |
| pin_in | input | 1 | Channel pin, already synchronous to clk |
| chr_wr | input | 1 | Write strobe for the channel register |
| chr_wdata | input | CNT_W | Channel register write data |
| chan_reg | output | CNT_W | Channel register contents |
| irq | output | 1 | Channel interrupt request |

## Verification
The hardest situation to reach is an event that falls inside the window between the arming read and the write of 0. Reaching it needs a pin edge placed in a precise cycle of an otherwise ordinary bus sequence. The stimulus reads the word with the flag set, which arms the clear. It then drops and raises the pin to inject a fresh capture. Only after that does it issue the write of 0, and it expects the flag to survive. A second clear attempt that follows a new read must then succeed, which shows that the cancel did not leave the channel stuck.

// File: rtl/tcf_pkg.sv
// Package: shared constants and the control-field layout of the timer
// channel status word. Assumes an 8-bit register bus.
package tcf_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = REG_W - 1;

    // Control fields of bits 6..0, most significant first.
    typedef struct packed {
        logic ie;    // interrupt enable
        logic msb;   // mode-select high
        logic msa;   // mode-select low
        logic elsb;  // edge select high
        logic elsa;  // edge select low
        logic tov;   // overflow toggle (stored only)
        logic dmax;  // max duty (stored only)
    } ctrl_t;
endpackage

// File: rtl/tcf_edge_sel.sv
// Edge selector: remembers the previous pin level and reports a hit when the
// selected edge kind occurs while enabled. Assumes pin is already synchronous.
module tcf_edge_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       en,
    input  logic [1:0] els,
    output logic       hit
);
    logic pin_q;
    logic rise;
    logic fall;
    logic pick;

    // Hold last pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
    assign fall = ~pin & pin_q;

    // Choose the active edge from the select pair; 00 disconnects.
    always_comb begin
        case (els)
            2'b01:   pick = rise;
            2'b10:   pick = fall;
            2'b11:   pick = rise | fall;
            default: pick = 1'b0;
        endcase
    end

    assign hit = en & pick;
endmodule

// File: rtl/tcf_match.sv
// Compare unit: flags every cycle in which the counter equals the channel
// register while compare mode is enabled.
module tcf_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_val,
    input  logic         en,
    output logic         hit
);
    // Equality test gated by mode.
    assign hit = en & (cnt == ref_val);
endmodule

// File: rtl/tcf_flag_ctl.sv
// Flag and arm logic: the flag sets on any event. A read seeing the flag
// arms a clear, a later write of 0 to the flag bit clears it only while
// armed, and a new event drops the arm. An event always wins over a clear.
module tcf_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_flag,
    output logic flag,
    output logic armed
);
    logic clr_ok;

    assign clr_ok = wr_hit & ~wr_flag & armed;

    // Sticky flag with event priority over the guarded clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (evt)    flag <= 1'b1;
        else if (clr_ok) flag <= 1'b0;
    end

    // Arm bit: set by a flag-set read, dropped by event or completed clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed <= 1'b0;
        else if (evt)             armed <= 1'b0;
        else if (clr_ok)          armed <= 1'b0;
        else if (rd_hit && flag)  armed <= 1'b1;
    end
endmodule

// File: rtl/tmr_chan_flag.sv
// Timer channel top: holds the control fields and the channel register,
// selects capture or compare mode, and drives the guarded event flag and
// interrupt. Assumes bus strobes are single-cycle and pin is synchronous.
module tmr_chan_flag
    import tcf_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_MSB = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             pin_in,
    input  logic             chr_wr,
    input  logic [CNT_W-1:0] chr_wdata,
    output logic [CNT_W-1:0] chan_reg,
    output logic             irq
);
    ctrl_t ctrl_q;
    ctrl_t wr_ctrl;
    logic  rd_hit;
    logic  wr_hit;
    logic  cap_mode;
    logic  cap_evt;
    logic  cmp_evt;
    logic  chan_evt;
    logic  flag_q;
    logic  armed_q;

    assign rd_hit = bus_sel & bus_rd;
    assign wr_hit = bus_sel & bus_wr;

    // Variant choice: with no high mode-select bit it is forced to 0.
    generate
        if (HAS_MSB) begin : g_msb
            assign wr_ctrl = ctrl_t'(bus_wdata[FLAG_BIT-1:0]);
        end else begin : g_nomsb
            always_comb begin
                wr_ctrl     = ctrl_t'(bus_wdata[FLAG_BIT-1:0]);
                wr_ctrl.msb = 1'b0;
            end
        end
    endgenerate

    // Control field register, written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= wr_ctrl;
    end

    assign cap_mode = ~ctrl_q.msa & ~ctrl_q.msb;

    tcf_edge_sel u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .en    (cap_mode),
        .els   ({ctrl_q.elsb, ctrl_q.elsa}),
        .hit   (cap_evt)
    );

    tcf_match #(.W(CNT_W)) u_match (
        .cnt     (cnt_val),
        .ref_val (chan_reg),
        .en      (~cap_mode),
        .hit     (cmp_evt)
    );

    assign chan_evt = cap_evt | cmp_evt;

    // Channel register: capture has priority over a bus load.
    always_ff @(posedge clk) begin
        if (!rst_n)       chan_reg <= '0;
        else if (cap_evt) chan_reg <= cnt_val;
        else if (chr_wr)  chan_reg <= chr_wdata;
    end

    tcf_flag_ctl u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (chan_evt),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit),
        .wr_flag (bus_wdata[FLAG_BIT]),
        .flag    (flag_q),
        .armed   (armed_q)
    );

    assign bus_rdata = {flag_q, ctrl_q};
    assign irq       = flag_q & ctrl_q.ie;
endmodule

// File: rtl/tcf_chk.sv
// Checker: temporal properties of the timer channel flag, attached to
// every instance of the top through a bind statement below.
module tcf_chk #(
    parameter int CNT_W   = 16,
    parameter bit HAS_MSB = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] chan_reg,
    input logic             irq,
    input logic             flag,
    input logic             armed,
    input logic             evt,
    input logic             cap_evt
);
    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    p_capture_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (chan_reg == $past(cnt_val)));

    p_read_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && !bus_wr && flag && !evt) |=> armed);

    p_no_clear_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);

    p_write_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[7] && !flag && !evt) |=> !flag);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (bus_rdata[7] && bus_rdata[6]));

    generate
        if (!HAS_MSB) begin : g_nomsb_chk
            p_msb_absent_r12: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[5] == 1'b0);
        end
    endgenerate
endmodule

bind tmr_chan_flag tcf_chk #(.CNT_W(CNT_W), .HAS_MSB(HAS_MSB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_val   (cnt_val),
    .chan_reg  (chan_reg),
    .irq       (irq),
    .flag      (flag_q),
    .armed     (armed_q),
    .evt       (chan_evt),
    .cap_evt   (cap_evt)
);

// File: tb/tmr_chan_flag_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor pops and
// compares them a quarter cycle after each falling clock edge.
`timescale 1ns/1ps
module tmr_chan_flag_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        sel2 = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  rdata2;
    logic [15:0] cnt_val = 16'h1234;
    logic        pin_in = 1'b0;
    logic        chr_wr = 1'b0;
    logic [15:0] chr_wdata = 16'h0000;
    logic [15:0] chan_reg;
    logic [15:0] chan_reg2;
    logic        irq;
    logic        irq2;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int          q_kind[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];
    event        mon_ev;

    always #10 clk = ~clk;

    tmr_chan_flag u_tmr_chan_flag (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .pin_in(pin_in), .chr_wr(chr_wr),
        .chr_wdata(chr_wdata), .chan_reg(chan_reg), .irq(irq)
    );

    tmr_chan_flag #(.HAS_MSB(1'b0)) u_tmr_chan_flag_nomsb (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel2), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
        .cnt_val(cnt_val), .pin_in(1'b0), .chr_wr(1'b0),
        .chr_wdata(16'h0000), .chan_reg(chan_reg2), .irq(irq2)
    );

    // Queue one expected item and release the monitor mid-cycle.
    task automatic expect_now(input int kind, input logic [15:0] exp, input string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        #5;
        -> mon_ev;
        #1;
    endtask

    task automatic rd_check(input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1;
        expect_now(0, {8'h00, exp}, tag);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd2_check(input logic [7:0] exp, input string tag);
        @(negedge clk);
        sel2 = 1'b1; bus_rd = 1'b1;
        expect_now(3, {8'h00, exp}, tag);
        @(negedge clk);
        sel2 = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [15:0] exp, input string tag);
        @(negedge clk);
        expect_now(kind, exp, tag);
    endtask

    task automatic wr(input logic [7:0] d, input bit second);
        @(negedge clk);
        if (second) sel2 = 1'b1; else bus_sel = 1'b1;
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; sel2 = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    // Monitor: pop expectations and compare against the selected output.
    initial begin
        forever begin
            int          k;
            logic [15:0] e;
            logic [15:0] act;
            string       t;
            @(mon_ev);
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            case (k)
                0:       act = {8'h00, bus_rdata};
                1:       act = chan_reg;
                2:       act = {15'h0000, irq};
                default: act = {8'h00, rdata2};
            endcase
            n_run++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, act, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(0, 16'h0000, "R1 status after reset");
        chk(2, 16'h0000, "R1 irq after reset");

        wr(8'h7F, 1'b0);
        rd_check(8'h7F, "R2 control bits read back");
        wr(8'hFF, 1'b0);
        rd_check(8'h7F, "R10 write one does not set flag");

        // Rising edge capture.
        wr(8'h04, 1'b0);
        cnt_val = 16'h1111;
        pin_to(1'b1);
        chk(1, 16'h1111, "R5 capture latches counter");
        rd_check(8'h84, "R3 rising edge sets flag");
        pin_to(1'b0);
        wr(8'h04, 1'b0);
        rd_check(8'h04, "R7 read then write zero clears");

        // Falling edge capture.
        wr(8'h08, 1'b0);
        cnt_val = 16'h2222;
        pin_to(1'b1);
        rd_check(8'h08, "R3 rising ignored in falling mode");
        pin_to(1'b0);
        rd_check(8'h88, "R3 falling edge sets flag");
        chk(1, 16'h2222, "R5 falling capture value");
        wr(8'h08, 1'b0);
        rd_check(8'h08, "R7 clear after falling capture");

        // Both edges.
        wr(8'h0C, 1'b0);
        cnt_val = 16'h3333;
        pin_to(1'b1);
        rd_check(8'h8C, "R3 both mode rising");
        wr(8'h0C, 1'b0);
        pin_to(1'b0);
        rd_check(8'h8C, "R3 both mode falling");
        wr(8'h0C, 1'b0);
        rd_check(8'h0C, "R7 clear in both mode");

        // Disconnected edge select.
        wr(8'h00, 1'b0);
        cnt_val = 16'h4444;
        pin_to(1'b1);
        pin_to(1'b0);
        rd_check(8'h00, "R4 edge select 00 sets no flag");
        chk(1, 16'h3333, "R4 channel register unchanged");

        // Write zero without arming read.
        wr(8'h04, 1'b0);
        pin_to(1'b1);
        wr(8'h04, 1'b0);
        rd_check(8'h84, "R8 unarmed write zero keeps flag");
        wr(8'h04, 1'b0);
        rd_check(8'h04, "R7 clear after late read");

        // Event between arming read and write of zero.
        pin_to(1'b0);
        pin_to(1'b1);
        rd_check(8'h84, "R9 flag set before window");
        pin_to(1'b0);
        pin_to(1'b1);
        wr(8'h04, 1'b0);
        rd_check(8'h84, "R9 event in window keeps flag");
        wr(8'h04, 1'b0);
        rd_check(8'h04, "R9 later clear still works");

        // Interrupt gating.
        wr(8'h44, 1'b0);
        pin_to(1'b0);
        pin_to(1'b1);
        chk(2, 16'h0001, "R11 irq with flag and enable");
        rd_check(8'hC4, "R11 status with enable");
        wr(8'h44, 1'b0);
        chk(2, 16'h0000, "R11 irq drops after clear");
        wr(8'h04, 1'b0);
        pin_to(1'b0);
        pin_to(1'b1);
        chk(2, 16'h0000, "R11 no irq when disabled");
        rd_check(8'h84, "R11 flag set while disabled");
        wr(8'h04, 1'b0);

        // Output compare.
        cnt_val = 16'h4FFF;
        wr(8'h10, 1'b0);
        @(negedge clk);
        chr_wr = 1'b1; chr_wdata = 16'h5000;
        @(negedge clk);
        chr_wr = 1'b0;
        rd_check(8'h10, "R6 no match no flag");
        @(negedge clk);
        cnt_val = 16'h5000;
        @(negedge clk);
        cnt_val = 16'h5001;
        rd_check(8'h90, "R6 match sets flag");
        chk(1, 16'h5000, "R6 compare leaves channel register");

        // Variant without high mode-select bit.
        wr(8'hFF, 1'b1);
        rd2_check(8'h5F, "R12 bit 5 absent in variant");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule